// File: doc/BRIEF.md
# Slow-Clock Seconds Counter with Alarm

This block keeps wall-clock time in a counter that advances on a slow, always-on clock of nominally 32 kHz. The counter is 47 bits wide. The upper 32 bits count whole seconds and the lower 15 bits count fractions of a second, so one second is 2^15 slow ticks. Software reaches the block through a simple 32-bit register port on a fast bus clock. It can start and stop the counter, load a new time, program a seconds value for the alarm, and enable the alarm and a wake-up output.

Every control bit crosses into the slow domain through a two-flop synchroniser. All slow-domain state returns to the bus side as one coherent snapshot that is taken once per slow cycle. As a result, a read of the run bit shows the state the counter has actually reached, not the value last written. Software loads a new time only while the counter is stopped, and then waits for the run bit to read back before relying on it.

When the seconds field equals the compare value while both the counter and the alarm are enabled, a sticky alarm flag is set. The flag drives an interrupt line, gated by the synchronised alarm enable, and a wake line, gated by the synchronised wake enable.

Top module: `rtc_lp_seconds`

## Requirements
- R1: After reset, every mapped register reads 0, and `irq_o` and `wake_o` are low.
- R2: While running, the count rises by exactly one per slow cycle. The low word carries into the high word, and seconds are count bits [46:15], so the low word bits [31:15] hold the seconds' low 17 bits.
- R3: CONTROL bit 0 reads back the synchronised run state. After a write, it changes no sooner than one and no later than three slow periods later.
- R4: Writes to COUNT_LO and COUNT_HI take effect only while the run readback is 0 and are ignored while it is 1. A stopped counter holds its value.
- R5: The alarm flag is set on a slow edge where run, alarm enable and seconds == ALARM all hold. It is never set while the alarm enable is 0.
- R6: STATUS bit 0 is the sticky alarm flag. Writing 1 to bit 0 clears it, and the change is visible within four slow periods. Writing 0 leaves it set.
- R7: `irq_o` is high when the flag is set and the synchronised alarm enable is 1. Clearing the alarm enable drops `irq_o` within three slow periods and leaves the flag set.
- R8: `wake_o` is high when the flag is set and the synchronised wake enable is 1.
- R9: GLITCH (0x30) stores the first value written after reset. Later writes are ignored.
- R10: The register offsets are CONTROL 0x04, STATUS 0x18, COUNT_HI 0x1C, COUNT_LO 0x20, ALARM 0x24 and GLITCH 0x30.
  - CONTROL holds bit 0 run, bit 1 alarm enable and bit 3 wake enable. Bits 1 and 3 read back as written.
  - COUNT_HI bits [14:0] hold count[46:32], and COUNT_LO holds count[31:0].
  - ALARM is a 32-bit seconds value.
  - Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register-port clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | Nominal 32 kHz time base |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq_o | output | 1 | Alarm interrupt, slow domain |
| wake_o | output | 1 | Wake request, slow domain |

## Verification
A register write lands on the next bus edge. Any effect in the slow domain needs two slow edges through the synchroniser and a third for the flag clear. A read then sees that effect about three bus cycles after the slow edge that produced it, once the snapshot has been captured. The bench therefore waits a whole number of slow periods past the worst case (three to five) before it compares a register or `irq_o` and `wake_o`. The run-bit latency is measured with time stamps and compared with the one-to-three slow period window. The per-cycle count step is sampled at two points exactly ten slow periods apart, so the expected difference is exact.

// File: rtl/rtc_lp_pkg.sv
`timescale 1ns/1ps
package rtc_lp_pkg;
    localparam int DATA_W = 32;
    localparam int SEC_W  = 32;
    localparam int FRAC_W = 15;
    localparam int CNT_W  = SEC_W + FRAC_W;
    localparam int HI_W   = CNT_W - DATA_W;
    localparam int ADDR_W = 8;
    localparam int SYNC_N = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 8'h04,
        A_STAT   = 8'h18,
        A_CNT_HI = 8'h1C,
        A_CNT_LO = 8'h20,
        A_ALARM  = 8'h24,
        A_GLITCH = 8'h30
    } reg_addr_e;

    localparam int BIT_RUN  = 0;
    localparam int BIT_ALM  = 1;
    localparam int BIT_WAKE = 3;
    localparam int BIT_FLAG = 0;

    typedef struct packed {
        logic wake_en;
        logic alarm_en;
        logic run_en;
    } ctrl_t;

    typedef struct packed {
        logic             run;
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } view_t;

    function automatic ctrl_t ctrl_from_word(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.wake_en  = w[BIT_WAKE];
        c.alarm_en = w[BIT_ALM];
        c.run_en   = w[BIT_RUN];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c, logic run_seen);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[BIT_RUN]  = run_seen;
        w[BIT_ALM]  = c.alarm_en;
        w[BIT_WAKE] = c.wake_en;
        return w;
    endfunction

    function automatic logic [SEC_W-1:0] seconds_of(logic [CNT_W-1:0] c);
        return c[CNT_W-1:FRAC_W];
    endfunction
endpackage

// File: rtl/rtc_lp_sync.sv
`timescale 1ns/1ps
module rtc_lp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rtc_lp_slow.sv
`timescale 1ns/1ps
module rtc_lp_slow
    import rtc_lp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_req,
    input  logic [SEC_W-1:0]  cmp,
    input  logic [CNT_W-1:0]  shadow,
    input  logic              ld_arm,
    input  logic              clr_tgl,
    output view_t             view_out,
    output logic              snap_tgl,
    output logic              irq_o,
    output logic              wake_o,
    output logic              run_s,
    output logic              alm_s,
    output logic              wake_s,
    output logic              ld_s,
    output logic              clr_pulse
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] sync_in, sync_out;
    logic             clr_s, clr_d, flag;
    logic [CNT_W-1:0] cnt;
    logic             match;

    assign sync_in = {ctrl_req.wake_en, ctrl_req.alarm_en, ctrl_req.run_en, ld_arm, clr_tgl};

    rtc_lp_sync #(.W(NSYNC), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (sync_out)
    );

    assign {wake_s, alm_s, run_s, ld_s, clr_s} = sync_out;
    assign clr_pulse = clr_s ^ clr_d;
    assign match     = (seconds_of(cnt) == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            flag     <= 1'b0;
            snap_tgl <= 1'b0;
            clr_d    <= 1'b0;
        end else begin
            snap_tgl <= ~snap_tgl;
            clr_d    <= clr_s;
            if (run_s)     cnt <= cnt + 1'b1;
            else if (ld_s) cnt <= shadow;
            if (run_s && alm_s && match) flag <= 1'b1;
            else if (clr_pulse)          flag <= 1'b0;
        end
    end

    assign irq_o    = flag & alm_s;
    assign wake_o   = flag & wake_s;
    assign view_out = '{run: run_s, flag: flag, cnt: cnt};
endmodule

// File: rtl/rtc_lp_bus.sv
`timescale 1ns/1ps
module rtc_lp_bus
    import rtc_lp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              snap_tgl,
    input  view_t             view_in,
    output ctrl_t             ctrl_q,
    output logic [SEC_W-1:0]  cmp_q,
    output logic [CNT_W-1:0]  shadow,
    output logic              ld_arm,
    output logic              clr_tgl,
    output logic [DATA_W-1:0] glitch_q,
    output logic              glitch_lock,
    output logic              seen_run
);
    logic  snap_sync, snap_d, cap;
    view_t view_cap;

    rtc_lp_sync #(.W(1), .STAGES(SYNC_N)) u_snap_sync (
        .clk (clk),
        .rst (rst),
        .d   (snap_tgl),
        .q   (snap_sync)
    );

    assign cap      = snap_sync ^ snap_d;
    assign seen_run = view_cap.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_d      <= 1'b0;
            view_cap    <= '0;
            ctrl_q      <= '0;
            cmp_q       <= '0;
            shadow      <= '0;
            ld_arm      <= 1'b0;
            clr_tgl     <= 1'b0;
            glitch_q    <= '0;
            glitch_lock <= 1'b0;
        end else begin
            snap_d <= snap_sync;
            if (cap) view_cap <= view_in;
            if (cap && view_in.run) ld_arm <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL:   ctrl_q <= ctrl_from_word(wr_data);
                    A_STAT:   if (wr_data[BIT_FLAG]) clr_tgl <= ~clr_tgl;
                    A_CNT_LO: if (!view_cap.run) begin
                        shadow[DATA_W-1:0] <= wr_data;
                        ld_arm             <= 1'b1;
                    end
                    A_CNT_HI: if (!view_cap.run) begin
                        shadow[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
                        ld_arm                 <= 1'b1;
                    end
                    A_ALARM:  cmp_q <= wr_data[SEC_W-1:0];
                    A_GLITCH: if (!glitch_lock) begin
                        glitch_q    <= wr_data;
                        glitch_lock <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:   rd_data = ctrl_to_word(ctrl_q, view_cap.run);
            A_STAT:   rd_data[BIT_FLAG] = view_cap.flag;
            A_CNT_HI: rd_data = DATA_W'(view_cap.cnt[CNT_W-1:DATA_W]);
            A_CNT_LO: rd_data = view_cap.cnt[DATA_W-1:0];
            A_ALARM:  rd_data = DATA_W'(cmp_q);
            A_GLITCH: rd_data = glitch_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_lp_seconds.sv
`timescale 1ns/1ps
module rtc_lp_seconds
    import rtc_lp_pkg::*;
(
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              slow_clk,
    input  logic              slow_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    output logic              wake_o
);
    ctrl_t             ctrl_q;
    logic [SEC_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  shadow;
    logic              ld_arm, clr_tgl, snap_tgl;
    logic [DATA_W-1:0] glitch_q;
    logic              glitch_lock, seen_run;
    view_t             view_s;
    logic              run_s, alm_s, wake_s, ld_s, clr_pulse;
    logic              flag_s;
    logic [CNT_W-1:0]  cnt_s;

    rtc_lp_bus u_bus (
        .clk         (bus_clk),
        .rst         (bus_rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .snap_tgl    (snap_tgl),
        .view_in     (view_s),
        .ctrl_q      (ctrl_q),
        .cmp_q       (cmp_q),
        .shadow      (shadow),
        .ld_arm      (ld_arm),
        .clr_tgl     (clr_tgl),
        .glitch_q    (glitch_q),
        .glitch_lock (glitch_lock),
        .seen_run    (seen_run)
    );

    rtc_lp_slow u_slow (
        .clk       (slow_clk),
        .rst       (slow_rst),
        .ctrl_req  (ctrl_q),
        .cmp       (cmp_q),
        .shadow    (shadow),
        .ld_arm    (ld_arm),
        .clr_tgl   (clr_tgl),
        .view_out  (view_s),
        .snap_tgl  (snap_tgl),
        .irq_o     (irq_o),
        .wake_o    (wake_o),
        .run_s     (run_s),
        .alm_s     (alm_s),
        .wake_s    (wake_s),
        .ld_s      (ld_s),
        .clr_pulse (clr_pulse)
    );

    assign flag_s = view_s.flag;
    assign cnt_s  = view_s.cnt;
endmodule

// File: rtl/rtc_lp_seconds_chk.sv
`timescale 1ns/1ps
module rtc_lp_seconds_chk
    import rtc_lp_pkg::*;
(
    input logic              bus_clk,
    input logic              bus_rst,
    input logic              slow_clk,
    input logic              slow_rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              seen_run,
    input logic [CNT_W-1:0]  shadow,
    input logic [DATA_W-1:0] glitch_q,
    input logic              glitch_lock,
    input logic              run_s,
    input logic              alm_s,
    input logic              wake_s,
    input logic              ld_s,
    input logic              clr_pulse,
    input logic              flag_s,
    input logic [CNT_W-1:0]  cnt_s,
    input logic [SEC_W-1:0]  cmp_q,
    input logic              irq_o,
    input logic              wake_o
);
    // R2: one step per slow cycle while running
    a_r2_count_step: assert property (@(posedge slow_clk) disable iff (slow_rst)
        run_s |=> cnt_s == $past(cnt_s) + 1'b1);

    // R4: a stopped, unarmed counter holds
    a_r4_hold_idle: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (!run_s && !ld_s) |=> $stable(cnt_s));

    // R4: count writes while running leave the load value alone
    a_r4_ignore_write: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && seen_run && (wr_addr == 8'h1C || wr_addr == 8'h20)) |=> $stable(shadow));

    // R5: a match with both enables sets the flag
    a_r5_alarm_sets: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (run_s && alm_s && cnt_s[CNT_W-1:FRAC_W] == cmp_q) |=> flag_s);

    // R5: never set while not armed
    a_r5_no_set_unarmed: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (!flag_s && !(run_s && alm_s)) |=> !flag_s);

    // R6: flag stays until a clear request arrives
    a_r6_sticky: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (flag_s && !clr_pulse) |=> flag_s);

    // R7: interrupt silent without alarm enable
    a_r7_irq_gated: assert property (@(posedge slow_clk) disable iff (slow_rst)
        !alm_s |-> !irq_o);

    // R8: wake silent without flag or wake enable
    a_r8_wake_gated: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (!flag_s || !wake_s) |-> !wake_o);

    // R9: locked pattern never changes
    a_r9_glitch_locked: assert property (@(posedge bus_clk) disable iff (bus_rst)
        glitch_lock |=> $stable(glitch_q));
endmodule

bind rtc_lp_seconds rtc_lp_seconds_chk u_chk (
    .bus_clk     (bus_clk),
    .bus_rst     (bus_rst),
    .slow_clk    (slow_clk),
    .slow_rst    (slow_rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .seen_run    (seen_run),
    .shadow      (shadow),
    .glitch_q    (glitch_q),
    .glitch_lock (glitch_lock),
    .run_s       (run_s),
    .alm_s       (alm_s),
    .wake_s      (wake_s),
    .ld_s        (ld_s),
    .clr_pulse   (clr_pulse),
    .flag_s      (flag_s),
    .cnt_s       (cnt_s),
    .cmp_q       (cmp_q),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
);

// File: tb/rtc_lp_seconds_bench.sv
`timescale 1ns/1ps
module rtc_lp_seconds_bench;
    import rtc_lp_pkg::*;

    localparam int SLOW = 20;   // bus cycles per slow period (5 ns vs 100 ns)

    logic        bus_clk = 1'b0, slow_clk = 1'b0;
    logic        bus_rst = 1'b1, slow_rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o, wake_o;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] mask;
        logic [31:0] exp;
        bit          cmp;
        string       tag;
    } sb_item_t;

    sb_item_t    sb_q[$];
    logic [31:0] last_rd;

    always #2.5 bus_clk = ~bus_clk;
    initial begin
        #7;
        forever #50 slow_clk = ~slow_clk;
    end

    rtc_lp_seconds u_rtc_lp_seconds (
        .bus_clk  (bus_clk),
        .bus_rst  (bus_rst),
        .slow_clk (slow_clk),
        .slow_rst (slow_rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq_o    (irq_o),
        .wake_o   (wake_o)
    );

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge bus_clk);
            if (sb_q.size() != 0) begin
                rd_addr = sb_q[0].addr;
                #1;
                last_rd = rd_data;
                if (sb_q[0].cmp) begin
                    n_tests++;
                    if ((rd_data & sb_q[0].mask) != (sb_q[0].exp & sb_q[0].mask)) begin
                        n_fail++;
                        $display("FAIL %s: reg %h actual %h expected %h", sb_q[0].tag,
                                 sb_q[0].addr, rd_data & sb_q[0].mask, sb_q[0].exp & sb_q[0].mask);
                    end
                end
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic drain();
        while (sb_q.size() != 0) @(posedge bus_clk);
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] m,
                              input logic [31:0] e, input string tag);
        sb_item_t it;
        it.addr = a; it.mask = m; it.exp = e; it.cmp = 1'b1; it.tag = tag;
        sb_q.push_back(it);
        drain();
    endtask

    task automatic sample(input logic [7:0] a, output logic [31:0] v);
        sb_item_t it;
        it.addr = a; it.mask = '0; it.exp = '0; it.cmp = 1'b0; it.tag = "";
        sb_q.push_back(it);
        drain();
        v = last_rd;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
        @(posedge bus_clk);
    endtask

    task automatic bus_wait(input int n);
        repeat (n) @(posedge bus_clk);
    endtask

    task automatic check_bit(input logic act, input logic e, input string tag);
        @(negedge bus_clk);
        #1;
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, e);
        end
    endtask

    task automatic check_val(input logic [31:0] act, input logic [31:0] e, input string tag);
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, e);
        end
    endtask

    // R3: run readback latency window after a CONTROL write
    task automatic run_latency(input logic [31:0] ctrl, input logic target, input string tag);
        logic [31:0] v;
        time         t0, lat;
        wr(8'h04, ctrl);
        t0 = $time;
        v  = ~ctrl;
        for (int i = 0; i < 200 && v[0] !== target; i++) sample(8'h04, v);
        lat = $time - t0;
        n_tests++;
        if (v[0] !== target || lat < 100 || lat > 300) begin
            n_fail++;
            $display("FAIL %s: actual latency %0t bit %b expected 100..300 ns bit %b",
                     tag, lat, v[0], target);
        end
    endtask

    initial begin
        repeat (400000) @(posedge bus_clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v1, v2;
        repeat (5) @(posedge slow_clk);
        @(negedge bus_clk);
        bus_rst  = 1'b0;
        slow_rst = 1'b0;
        bus_wait(2);

        // R1: reset state
        expect_reg(8'h04, '1, 32'h0, "R1 ctrl");
        expect_reg(8'h18, '1, 32'h0, "R1 status");
        expect_reg(8'h1C, '1, 32'h0, "R1 count_hi");
        expect_reg(8'h20, '1, 32'h0, "R1 count_lo");
        expect_reg(8'h24, '1, 32'h0, "R1 alarm");
        expect_reg(8'h30, '1, 32'h0, "R1 glitch");
        check_bit(irq_o, 1'b0, "R1 irq");
        check_bit(wake_o, 1'b0, "R1 wake");

        // R9: write-once pattern register
        wr(8'h30, 32'h41736166);
        expect_reg(8'h30, '1, 32'h41736166, "R9 first write");
        wr(8'h30, 32'h0);
        expect_reg(8'h30, '1, 32'h41736166, "R9 second write ignored");

        // R10: map
        wr(8'h24, 32'h0000_1234);
        expect_reg(8'h24, '1, 32'h0000_1234, "R10 alarm reg");
        expect_reg(8'h08, '1, 32'h0, "R10 unmapped");

        // R4: load while stopped
        wr(8'h20, 32'hFFFF_FFF0);
        wr(8'h1C, 32'h0000_0003);
        bus_wait(5 * SLOW);
        expect_reg(8'h20, '1, 32'hFFFF_FFF0, "R4 load lo");
        expect_reg(8'h1C, '1, 32'h0000_0003, "R4 load hi");

        // R3: enable readback latency
        run_latency(32'h1, 1'b1, "R3 run rise");

        // R2: exact step over ten slow periods
        sample(8'h20, v1);
        bus_wait(10 * SLOW - 1);
        sample(8'h20, v2);
        check_val(v2 - v1, 32'd10, "R2 step per slow cycle");
        bus_wait(20 * SLOW);
        expect_reg(8'h1C, '1, 32'h0000_0004, "R2 carry into hi");

        // R4: writes ignored while running
        wr(8'h20, 32'h0);
        wr(8'h1C, 32'h0);
        bus_wait(5 * SLOW);
        expect_reg(8'h1C, '1, 32'h0000_0004, "R4 write while running ignored");

        run_latency(32'h0, 1'b0, "R3 run fall");
        sample(8'h20, v1);
        bus_wait(10 * SLOW);
        sample(8'h20, v2);
        check_val(v2, v1, "R4 stopped counter holds");
        expect_reg(8'h1C, '1, 32'h0000_0004, "R4 hi held after stop");

        // R5/R7/R8: alarm at second 101
        wr(8'h20, 32'h0032_7FF0);
        wr(8'h1C, 32'h0);
        wr(8'h24, 32'd101);
        bus_wait(5 * SLOW);
        expect_reg(8'h20, '1, 32'h0032_7FF0, "R4 reload while stopped");
        wr(8'h04, 32'h0B);
        bus_wait(3 * SLOW);
        expect_reg(8'h18, '1, 32'h0, "R5 no flag before match");
        check_bit(irq_o, 1'b0, "R7 irq low before match");
        bus_wait(40 * SLOW);
        expect_reg(8'h18, '1, 32'h1, "R5 flag at match");
        check_bit(irq_o, 1'b1, "R7 irq with flag");
        check_bit(wake_o, 1'b1, "R8 wake with flag");
        expect_reg(8'h20, 32'hFFFF_8000, 32'd101 << 15, "R2 seconds field");
        expect_reg(8'h04, '1, 32'h0B, "R10 ctrl readback");

        // R6: writing 0 does not clear
        wr(8'h18, 32'h0);
        bus_wait(5 * SLOW);
        expect_reg(8'h18, '1, 32'h1, "R6 write 0 keeps flag");

        // R7: alarm enable off drops irq, flag stays
        wr(8'h04, 32'h09);
        bus_wait(3 * SLOW);
        check_bit(irq_o, 1'b0, "R7 irq drops with alarm enable");
        check_bit(wake_o, 1'b1, "R8 wake stays with wake enable");
        expect_reg(8'h18, '1, 32'h1, "R6 flag sticky");

        // R6: write 1 clears
        wr(8'h18, 32'h1);
        bus_wait(4 * SLOW);
        expect_reg(8'h18, '1, 32'h0, "R6 clear");
        check_bit(wake_o, 1'b0, "R8 wake low after clear");

        // R5: match with alarm disabled sets nothing
        wr(8'h04, 32'h0);
        bus_wait(5 * SLOW);
        wr(8'h20, 32'h0032_7FF0);
        wr(8'h1C, 32'h0);
        bus_wait(5 * SLOW);
        wr(8'h04, 32'h09);
        bus_wait(40 * SLOW);
        expect_reg(8'h20, 32'hFFFF_8000, 32'd101 << 15, "R2 second reached again");
        expect_reg(8'h18, '1, 32'h0, "R5 no flag without alarm enable");
        check_bit(irq_o, 1'b0, "R7 irq low unarmed");
        check_bit(wake_o, 1'b0, "R8 wake low unarmed");

        wr(8'h04, 32'h0);
        bus_wait(5 * SLOW);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule